// File: doc/BRIEF.md
# ARX-Box Permutation Core

This block applies a keyless permutation to a 64-bit value held as two 32-bit words, a left word and a right word. A 32-bit constant chosen per call selects one member of the permutation family. One evaluation is four add-rotate-xor rounds. Each round has its own pair of rotation amounts. In each round the left word absorbs a rotated copy of the right word by modular addition. The right word then absorbs a rotated copy of the new left word by XOR. Last, the constant is XORed into the left word only.

A caller waits until `busy` is low, then presents the two words and the constant with a one-cycle `start`. The core captures all three on that edge. By default it iterates one round per clock, stepping a 2-bit round index through a small table of rotation pairs. It raises `done` for a single cycle when the result is on `xOut`/`yOut`. Setting the `UNROLL` parameter builds all four rounds as one combinational chain instead. The handshake stays the same, but the result arrives one cycle after `start`. Two evaluations chained through the caller form the double box.

Top module: `arx_box_core`

## Requirements
- R1: While reset is high and in the first cycle after it, `busy` and `done` are 0 and `xOut`/`yOut` read zero.
- R2: Each round does three steps in this order: left = left + rotr(right, r) mod 2^32 with the carry out dropped, then right = right XOR rotr(left, s), then left = left XOR constant.
- R3: The rotation pairs (r, s) are (31,24) in the first round, (17,17) in the second, (0,31) in the third and (24,16) in the fourth. All rotations are cyclic right rotations of a 32-bit word.
- R4: The same constant is XORed into the left word in all four rounds. Nothing is XORed into the right word.
- R5: In the iterative build, `done` is high in exactly one cycle. That cycle follows the fourth rising edge after the edge that accepts `start`.
- R6: `busy` is high from the accepting edge until `done` rises, and never at the same time as `done`. A `start` seen while `busy` is high has no effect on the result or on the `done` timing.
- R7: The words and the constant are captured on the accepting edge. Later changes on `xIn`, `yIn` and `cIn` do not change the result. While idle with no `start`, `xOut`/`yOut` hold their value.
- R8: With `UNROLL` set, `done` is high for one cycle right after the accepting edge. The result is the same as in the iterative build.
- R9: The result matches the four-round permutation for each of the eight working constants b7e15162, bf715880, 38b4da56, 324e7738, bb1185eb, 4f7c7b57, cfbfa1c8 and c2b3293d. It also matches for all-zero and all-ones inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request an evaluation; accepted only when `busy` is low |
| xIn | input | 32 | Left input word |
| yIn | input | 32 | Right input word |
| cIn | input | 32 | Per-call constant |
| busy | output | 1 | Evaluation in progress; `start` is ignored |
| done | output | 1 | One-cycle strobe: `xOut`/`yOut` hold the result |
| xOut | output | 32 | Left result word |
| yOut | output | 32 | Right result word |

## Verification
Some properties are checked on every cycle: the gap from acceptance to `done` (R5, R8), that `done` lasts one cycle, that `busy` and `done` never overlap (R6), and that the outputs hold steady when the core is idle (R7). The values themselves are checked only by the bench's scenarios. These scenarios compare each result against an arithmetic model of the rounds (R2 to R4, R9) in both builds. They also check that inputs are latched and a `start` during `busy` is dropped, by scrambling the inputs after acceptance and re-requesting mid-run.

// File: rtl/arx_box_pkg.sv
package arx_box_pkg;
  localparam int WORD_W = 32;
  localparam int ROUNDS = 4;
  localparam int RND_W  = $clog2(ROUNDS);
  localparam int ROT_W  = $clog2(WORD_W);

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [RND_W-1:0]  rnd_t;
  typedef logic [ROT_W-1:0]  amt_t;

  typedef struct packed {
    word_t x;
    word_t y;
  } pair_t;

  typedef struct packed {
    amt_t r;
    amt_t s;
  } rot_t;

  typedef struct packed {
    logic load;
    logic step;
    rnd_t rnd;
  } dpCtrl_t;

  function automatic word_t rotR(word_t w, amt_t n);
    logic [2*WORD_W-1:0] dbl;
    dbl = {w, w} >> n;
    return dbl[WORD_W-1:0];
  endfunction

  function automatic rot_t rotPair(rnd_t idx);
    rot_t k;
    case (idx)
      rnd_t'(0): begin k.r = amt_t'(31); k.s = amt_t'(24); end
      rnd_t'(1): begin k.r = amt_t'(17); k.s = amt_t'(17); end
      rnd_t'(2): begin k.r = amt_t'(0);  k.s = amt_t'(31); end
      default:   begin k.r = amt_t'(24); k.s = amt_t'(16); end
    endcase
    return k;
  endfunction

  function automatic pair_t arxRound(pair_t p, word_t c, rot_t k);
    pair_t q;
    word_t sumX;
    sumX = p.x + rotR(p.y, k.r);
    q.y  = p.y ^ rotR(sumX, k.s);
    q.x  = sumX ^ c;
    return q;
  endfunction
endpackage

// File: rtl/arx_ctrl.sv
module arx_ctrl
  import arx_box_pkg::*;
#(
  parameter bit UNROLL = 1'b0
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    start,
  output logic    busy,
  output logic    done,
  output dpCtrl_t ctl
);
  logic busyQ;
  logic doneQ;
  rnd_t rndQ;
  logic accept;

  assign accept = start & ~busyQ;

  generate
    if (UNROLL) begin : g_flat
      assign busyQ = 1'b0;
      assign rndQ  = '0;
      always_ff @(posedge clk) begin
        if (rst) doneQ <= 1'b0;
        else     doneQ <= accept;
      end
    end else begin : g_iter
      always_ff @(posedge clk) begin
        if (rst) begin
          busyQ <= 1'b0;
          doneQ <= 1'b0;
          rndQ  <= '0;
        end else begin
          doneQ <= 1'b0;
          if (accept) begin
            busyQ <= 1'b1;
            rndQ  <= '0;
          end else if (busyQ) begin
            rndQ <= rndQ + rnd_t'(1);
            if (rndQ == rnd_t'(ROUNDS - 1)) begin
              busyQ <= 1'b0;
              doneQ <= 1'b1;
            end
          end
        end
      end
    end
  endgenerate

  assign ctl.load = accept;
  assign ctl.step = busyQ;
  assign ctl.rnd  = rndQ;
  assign busy     = busyQ;
  assign done     = doneQ;
endmodule

// File: rtl/arx_dpath.sv
module arx_dpath
  import arx_box_pkg::*;
#(
  parameter bit UNROLL = 1'b0
) (
  input  logic    clk,
  input  logic    rst,
  input  dpCtrl_t ctl,
  input  word_t   xIn,
  input  word_t   yIn,
  input  word_t   cIn,
  output word_t   xOut,
  output word_t   yOut
);
  pair_t stQ;
  word_t cQ;
  pair_t loadVal;

  generate
    if (UNROLL) begin : g_flat
      pair_t stage [ROUNDS+1];
      assign stage[0] = {xIn, yIn};
      for (genvar g = 0; g < ROUNDS; g++) begin : g_rnd
        assign stage[g+1] = arxRound(stage[g], cIn, rotPair(rnd_t'(g)));
      end
      assign loadVal = stage[ROUNDS];
    end else begin : g_iter
      assign loadVal = {xIn, yIn};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      stQ <= '0;
      cQ  <= '0;
    end else if (ctl.load) begin
      stQ <= loadVal;
      cQ  <= cIn;
    end else if (ctl.step) begin
      stQ <= arxRound(stQ, cQ, rotPair(ctl.rnd));
    end
  end

  assign xOut = stQ.x;
  assign yOut = stQ.y;
endmodule

// File: rtl/arx_box_core.sv
module arx_box_core
  import arx_box_pkg::*;
#(
  parameter bit UNROLL = 1'b0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic [31:0] xIn,
  input  logic [31:0] yIn,
  input  logic [31:0] cIn,
  output logic        busy,
  output logic        done,
  output logic [31:0] xOut,
  output logic [31:0] yOut
);
  dpCtrl_t ctl;

  arx_ctrl #(.UNROLL(UNROLL)) u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .busy  (busy),
    .done  (done),
    .ctl   (ctl)
  );

  arx_dpath #(.UNROLL(UNROLL)) u_dpath (
    .clk  (clk),
    .rst  (rst),
    .ctl  (ctl),
    .xIn  (xIn),
    .yIn  (yIn),
    .cIn  (cIn),
    .xOut (xOut),
    .yOut (yOut)
  );
endmodule

// File: rtl/arx_box_chk.sv
module arx_box_chk #(
  parameter bit UNROLL = 1'b0
) (
  input logic        clk,
  input logic        rst,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic [31:0] xOut,
  input logic [31:0] yOut
);
  localparam logic [2:0] LAT = UNROLL ? 3'd1 : 3'(arx_box_pkg::ROUNDS + 1);

  logic [2:0] sinceAcc;
  always_ff @(posedge clk) begin
    if (rst)                               sinceAcc <= 3'd0;
    else if (start && !busy)               sinceAcc <= 3'd1;
    else if (sinceAcc != 3'd0 && sinceAcc != 3'd7) sinceAcc <= sinceAcc + 3'd1;
  end

  // R5
  done_latency_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (sinceAcc == LAT));

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R6
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> ($stable(xOut) && $stable(yOut)));

  generate
    if (!UNROLL) begin : g_iter
      // R6
      busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);
    end
  endgenerate
endmodule

bind arx_box_core arx_box_chk #(.UNROLL(UNROLL)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .start (start),
  .busy  (busy),
  .done  (done),
  .xOut  (xOut),
  .yOut  (yOut)
);

// File: tb/tb_arx_box_core.sv
module tb_arx_box_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        startU = 1'b0;
  logic [31:0] xIn = '0, yIn = '0, cIn = '0;
  logic        busy, done, busyU, doneU;
  logic [31:0] xOut, yOut, xOutU, yOutU;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  arx_box_core #(.UNROLL(1'b0)) dut (
    .clk(clk), .rst(rst), .start(start), .xIn(xIn), .yIn(yIn), .cIn(cIn),
    .busy(busy), .done(done), .xOut(xOut), .yOut(yOut));

  arx_box_core #(.UNROLL(1'b1)) dutU (
    .clk(clk), .rst(rst), .start(startU), .xIn(xIn), .yIn(yIn), .cIn(cIn),
    .busy(busyU), .done(doneU), .xOut(xOutU), .yOut(yOutU));

  function automatic logic [31:0] rr(logic [31:0] v, int n);
    return (n == 0) ? v : ((v >> n) | (v << (32 - n)));
  endfunction

  function automatic logic [63:0] model(logic [31:0] x, logic [31:0] y, logic [31:0] c);
    int ra [4] = '{31, 17, 0, 24};
    int sa [4] = '{24, 17, 31, 16};
    for (int i = 0; i < 4; i++) begin
      x = x + rr(y, ra[i]);
      y = y ^ rr(x, sa[i]);
      x = x ^ c;
    end
    return {x, y};
  endfunction

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic runVec(logic [31:0] x, logic [31:0] y, logic [31:0] c, string tag);
    logic [63:0] exp;
    exp = model(x, y, c);
    @(negedge clk);
    start = 1'b1; startU = 1'b1; xIn = x; yIn = y; cIn = c;
    @(negedge clk); // one edge after acceptance
    start = 1'b0; startU = 1'b0; xIn = ~x; yIn = x ^ y; cIn = ~c;
    check(doneU === 1'b1, "R8 flat done", {63'd0, doneU}, 64'd1);
    check({xOutU, yOutU} === exp, "R8 flat result", {xOutU, yOutU}, exp);
    check(busy === 1'b1 && done === 1'b0, "R6 busy after accept", {62'd0, busy, done}, 64'd2);
    @(negedge clk);
    start = 1'b1; // ignored while busy
    check(done === 1'b0, "R5 early done", {63'd0, done}, 64'd0);
    check(doneU === 1'b0, "R8 flat pulse", {63'd0, doneU}, 64'd0);
    @(negedge clk);
    start = 1'b0;
    check(done === 1'b0, "R5 early done", {63'd0, done}, 64'd0);
    @(negedge clk);
    check(done === 1'b0, "R5 early done", {63'd0, done}, 64'd0);
    @(negedge clk);
    check(done === 1'b1, "R5 done timing", {63'd0, done}, 64'd1);
    check(busy === 1'b0, "R6 busy clear", {63'd0, busy}, 64'd0);
    check({xOut, yOut} === exp, tag, {xOut, yOut}, exp);
    @(negedge clk);
    check(done === 1'b0, "R5 single pulse", {63'd0, done}, 64'd0);
    check({xOut, yOut} === exp, "R7 hold", {xOut, yOut}, exp);
  endtask

  initial begin
    logic [31:0] consts [8] = '{32'hb7e15162, 32'hbf715880, 32'h38b4da56, 32'h324e7738,
                                32'hbb1185eb, 32'h4f7c7b57, 32'hcfbfa1c8, 32'hc2b3293d};
    repeat (3) @(negedge clk);
    check(busy === 1'b0 && done === 1'b0, "R1 in reset", {62'd0, busy, done}, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check(busy === 1'b0 && done === 1'b0, "R1 after reset", {62'd0, busy, done}, 64'd0);
    check({xOut, yOut} === 64'd0, "R1 outputs", {xOut, yOut}, 64'd0);
    check(doneU === 1'b0 && busyU === 1'b0, "R1 flat", {62'd0, busyU, doneU}, 64'd0);

    runVec(32'd0, 32'd0, 32'd0, "R9 all zero");
    runVec(32'hffffffff, 32'hffffffff, 32'hffffffff, "R9 all ones");
    runVec(32'hffffffff, 32'hffffffff, consts[0], "R9 ones with constant");
    runVec(32'd0, 32'd0, consts[3], "R4 constant only in left");
    runVec(32'h00000001, 32'd0, 32'd0, "R3 single bit left");
    runVec(32'd0, 32'h80000000, 32'd0, "R3 single bit right");
    runVec(32'hffffffff, 32'h00000001, 32'd0, "R2 carry dropped");
    for (int i = 0; i < 8; i++) runVec($urandom, $urandom, consts[i], "R9 working constant");
    for (int i = 0; i < 20; i++) runVec($urandom, $urandom, $urandom, "R2 random");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule